// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block is the digital controller in front of a successive-approximation converter. It decides when a conversion starts, which analog channels are converted and in what order, and when the converter's sample-and-hold and conversion phases are active. A software write can start a sequence, and so can an external trigger pin or a conversion request from a timer. Each hardware source has its own enable bit. A hardware start sets the same start/busy bit that software uses, so every later step follows the same timing.

The first conversion of a sequence waits for a start delay and then samples for a fixed time before converting. The start delay depends on where the start request falls relative to an internal conversion clock, which runs at the system clock divided by four. Later channels of a multi-channel or scan sequence skip the delay and the sampling and run on a short fixed schedule. A stub converter returns a result a fixed number of cycles after each conversion is launched. The sequencer presents that result together with the index of the channel it belongs to.

Top module: `adc_start_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `sh_active`, `conv_active`, `result_valid` and `eoc` are all 0.
- R2: With the sequencer idle, a start request sets `busy` one cycle later. A pulse on `sw_start_set` always counts as a request. A pulse on `ext_trig` counts only when `trig_sel[0]` is 1, and a pulse on `tmr_req` counts only when `trig_sel[1]` is 1. `trig_sel[3:2]` have no effect.
- R3: Let p be the number of clock edges since reset release, modulo 4, in the cycle the request is presented. The start delay is tD = (4 - p) + 2 cycles, counted from the edge that accepts the request. The formula is the same for all three sources. `sh_active` first goes high tD cycles after that edge.
- R4: `sh_active` is high for exactly 8 cycles per sequence, and only before the first conversion.
- R5: Each conversion holds `conv_active` high for 10 cycles. `result_valid` pulses in the next cycle, with `result_chan` set to the converted channel c and `result_data` = 100*c + 33. The first result arrives tD + 18 cycles after the accepting edge.
- R6: `mode` uses 00 for single, 01 for multi, 10 for scan, and 11 behaves as single. Single mode converts channel `chan_sel`. Multi and scan modes convert channels 0 to `chan_sel` in ascending order.
- R7: After the first conversion, each further result follows the previous one by exactly 12 cycles: a 2-cycle gap followed by 10 conversion cycles.
- R8: In single and multi modes, `busy` clears and `eoc` pulses for one cycle in the same cycle as the last `result_valid`.
- R9: In scan mode, `busy` stays high and the channel group repeats on the 12-cycle spacing. `eoc` pulses with the last result of each pass and with no other result.
- R10: While busy, start requests from every source are ignored. Changes to `mode` and `chan_sel` do not alter the sequence in progress.
- R11: A pulse on `sw_start_clr` while busy ends the sequence. `busy` is 0 in the next cycle, and no further `result_valid` or `eoc` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_start_set | input | 1 | Software write of 1 to the start bit (pulse) |
| sw_start_clr | input | 1 | Software write of 0 to the start bit (pulse) |
| trig_sel | input | 4 | Hardware start enables: bit 0 external pin, bit 1 timer |
| ext_trig | input | 1 | External trigger pulse |
| tmr_req | input | 1 | Timer conversion request pulse |
| mode | input | 2 | Sequence mode: 00 single, 01 multi, 10 scan, 11 single |
| chan_sel | input | 3 | Channel field (single channel or last channel of a group) |
| busy | output | 1 | Start/busy bit |
| sh_active | output | 1 | Sample-and-hold phase active |
| conv_active | output | 1 | Conversion phase active |
| chan_idx | output | 3 | Channel currently in progress |
| result_valid | output | 1 | One-cycle result strobe |
| result_data | output | 10 | Converted value |
| result_chan | output | 3 | Channel of the presented result |
| eoc | output | 1 | End of sequence (or end of scan pass) pulse |

## Verification
The bench starts single-channel sequences from each of the three sources at all four divider phases. This shows whether the delay follows the phase of the request and whether hardware and software starts get the same timing. Multi-mode runs with group sizes of one, four and eight channels separate the long first-conversion schedule from the short later one, and the runs with code 11 and `chan_sel` 0 check the single-channel corner cases. A scan run that receives stray triggers and configuration changes while busy, and is then cleared, shows that the group wraps and that requests are ignored while busy. An abort in the middle of a multi sequence, and hardware pulses with only the reserved enable bits set, show that a clear and an unselected source leave no trace.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      MD_SINGLE     = 2'b00,
      MD_MULTI      = 2'b01,
      MD_SCAN       = 2'b10,
      MD_SINGLE_ALT = 2'b11
   } seq_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_DELAY  = 3'd1,
      ST_SAMPLE = 3'd2,
      ST_CONV   = 3'd3,
      ST_GAP    = 3'd4
   } seq_state_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/adc_seq_phase.sv
// Free-running divider phase; its value picks the start delay.
module adc_seq_phase #(
   parameter int DIV  = 4,
   localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PH_W-1:0] phase
);
   localparam logic [PH_W-1:0] PH_ONE  = 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

   generate
      if ((DIV & (DIV - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk) begin
            if (!rst_n) phase <= '0;
            else        phase <= phase + PH_ONE;
         end
      end else begin : g_modulo
         always_ff @(posedge clk) begin
            if (!rst_n)                phase <= '0;
            else if (phase == PH_LAST) phase <= '0;
            else                       phase <= phase + PH_ONE;
         end
      end
   endgenerate
endmodule

// File: rtl/adc_seq_trig.sv
// Qualifies the three start sources into a single request.
module adc_seq_trig #(
   parameter int TRG_W   = 4,
   parameter int EXT_BIT = 0,
   parameter int TMR_BIT = 1
) (
   input  logic [TRG_W-1:0] trig_sel,
   input  logic             sw_set,
   input  logic             ext_trig,
   input  logic             tmr_req,
   output logic             start_req
);
   logic [TRG_W-1:0] src_vec;
   logic             unused_sel;

   generate
      for (genvar i = 0; i < TRG_W; i++) begin : g_src
         if (i == EXT_BIT) begin : g_ext
            assign src_vec[i] = trig_sel[i] & ext_trig;
         end else if (i == TMR_BIT) begin : g_tmr
            assign src_vec[i] = trig_sel[i] & tmr_req;
         end else begin : g_rsvd
            assign src_vec[i] = 1'b0;
         end
      end
   endgenerate

   assign unused_sel = ^trig_sel;
   assign start_req  = sw_set | (|src_vec);
endmodule

// File: rtl/adc_conv_stub.sv
// Stand-in converter: result ready a fixed number of cycles after launch.
module adc_conv_stub #(
   parameter int CH_W     = 3,
   parameter int RES_W    = 10,
   parameter int CONV_CYC = 10,
   parameter int RES_STEP = 100,
   parameter int RES_OFS  = 33,
   localparam int CC_W    = $clog2(CONV_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             flush,
   input  logic [CH_W-1:0]  chan,
   output logic             done,
   output logic [RES_W-1:0] result
);
   localparam logic [CC_W-1:0] CC_ONE  = 1;
   localparam logic [CC_W-1:0] CC_LOAD = CC_W'(CONV_CYC - 1);

   logic            act;
   logic [CC_W-1:0] cc;
   logic [CH_W-1:0] chan_l;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         act    <= 1'b0;
         cc     <= '0;
         chan_l <= '0;
      end else if (launch) begin
         act    <= 1'b1;
         cc     <= CC_LOAD;
         chan_l <= chan;
      end else if (act) begin
         if (cc == '0) act <= 1'b0;
         else          cc  <= cc - CC_ONE;
      end
   end

   assign done   = act && (cc == '0);
   assign result = RES_W'(chan_l) * RES_W'(RES_STEP) + RES_W'(RES_OFS);
endmodule

// File: rtl/adc_seq_ctrl.sv
// Sequence state machine: delay, sampling, conversions and channel stepping.
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int CH_W    = 3,
   parameter int RES_W   = 10,
   parameter int DIV     = 4,
   parameter int PAD_CYC = 2,
   parameter int SPL_CYC = 8,
   parameter int GAP_CYC = 2,
   localparam int PH_W   = (DIV > 1) ? $clog2(DIV) : 1,
   localparam int CNT_W  = $clog2(max3(DIV + PAD_CYC, SPL_CYC, GAP_CYC) + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             abort,
   input  logic [PH_W-1:0]  phase,
   input  logic [1:0]       mode,
   input  logic [CH_W-1:0]  chan_sel,
   input  logic             conv_done,
   input  logic [RES_W-1:0] conv_res,
   output logic             launch,
   output logic             busy,
   output logic             sh_active,
   output logic             conv_active,
   output logic [CH_W-1:0]  chan_idx,
   output logic             result_valid,
   output logic [RES_W-1:0] result_data,
   output logic [CH_W-1:0]  result_chan,
   output logic             eoc
);
   localparam logic [CNT_W-1:0] CNT_ONE  = 1;
   localparam logic [CNT_W-1:0] TD_BASE  = CNT_W'(DIV + PAD_CYC - 1);
   localparam logic [CNT_W-1:0] SPL_LOAD = CNT_W'(SPL_CYC - 1);
   localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYC - 1);
   localparam logic [CH_W-1:0]  CH_ONE   = 1;

   seq_state_e      st;
   seq_mode_e       md_in;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] td_load;
   logic [CH_W-1:0]  chan;
   logic [CH_W-1:0]  first_ch;
   logic [CH_W-1:0]  last_ch;
   logic             scan_q;
   logic             single_in;

   assign md_in     = seq_mode_e'(mode);
   assign single_in = (md_in == MD_SINGLE) || (md_in == MD_SINGLE_ALT);
   assign td_load   = TD_BASE - CNT_W'(phase);

   assign launch = !abort && (cnt == '0) &&
                   ((st == ST_SAMPLE) || (st == ST_GAP));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         cnt          <= '0;
         chan         <= '0;
         first_ch     <= '0;
         last_ch      <= '0;
         scan_q       <= 1'b0;
         busy         <= 1'b0;
         eoc          <= 1'b0;
         result_valid <= 1'b0;
         result_data  <= '0;
         result_chan  <= '0;
      end else begin
         eoc          <= 1'b0;
         result_valid <= 1'b0;
         if (abort) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            busy <= 1'b0;
         end else begin
            unique case (st)
               ST_IDLE: begin
                  if (start_req) begin
                     busy     <= 1'b1;
                     st       <= ST_DELAY;
                     cnt      <= td_load;
                     first_ch <= single_in ? chan_sel : '0;
                     chan     <= single_in ? chan_sel : '0;
                     last_ch  <= chan_sel;
                     scan_q   <= (md_in == MD_SCAN);
                  end
               end
               ST_DELAY: begin
                  if (cnt == '0) begin
                     st  <= ST_SAMPLE;
                     cnt <= SPL_LOAD;
                  end else begin
                     cnt <= cnt - CNT_ONE;
                  end
               end
               ST_SAMPLE: begin
                  if (cnt == '0) st  <= ST_CONV;
                  else           cnt <= cnt - CNT_ONE;
               end
               ST_CONV: begin
                  if (conv_done) begin
                     result_valid <= 1'b1;
                     result_data  <= conv_res;
                     result_chan  <= chan;
                     if (chan == last_ch) begin
                        eoc <= 1'b1;
                        if (scan_q) begin
                           chan <= first_ch;
                           st   <= ST_GAP;
                           cnt  <= GAP_LOAD;
                        end else begin
                           st   <= ST_IDLE;
                           busy <= 1'b0;
                        end
                     end else begin
                        chan <= chan + CH_ONE;
                        st   <= ST_GAP;
                        cnt  <= GAP_LOAD;
                     end
                  end
               end
               ST_GAP: begin
                  if (cnt == '0) st  <= ST_CONV;
                  else           cnt <= cnt - CNT_ONE;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign sh_active   = (st == ST_SAMPLE);
   assign conv_active = (st == ST_CONV);
   assign chan_idx    = chan;
endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq #(
   parameter int CH_W     = 3,
   parameter int TRG_W    = 4,
   parameter int RES_W    = 10,
   parameter int DIV      = 4,
   parameter int PAD_CYC  = 2,
   parameter int SPL_CYC  = 8,
   parameter int CONV_CYC = 10,
   parameter int GAP_CYC  = 2,
   parameter int EXT_BIT  = 0,
   parameter int TMR_BIT  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_start_set,
   input  logic             sw_start_clr,
   input  logic [TRG_W-1:0] trig_sel,
   input  logic             ext_trig,
   input  logic             tmr_req,
   input  logic [1:0]       mode,
   input  logic [CH_W-1:0]  chan_sel,
   output logic             busy,
   output logic             sh_active,
   output logic             conv_active,
   output logic [CH_W-1:0]  chan_idx,
   output logic             result_valid,
   output logic [RES_W-1:0] result_data,
   output logic [CH_W-1:0]  result_chan,
   output logic             eoc
);
   localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("DIV must be at least 2");
      end
      if (SPL_CYC < 1 || CONV_CYC < 1 || GAP_CYC < 1) begin : g_bad_time
         $error("sampling, conversion and gap lengths must be at least 1");
      end
      if (PAD_CYC < 0) begin : g_bad_pad
         $error("PAD_CYC must not be negative");
      end
      if (EXT_BIT == TMR_BIT || EXT_BIT >= TRG_W || TMR_BIT >= TRG_W) begin : g_bad_bits
         $error("trigger enable bits must be distinct and inside trig_sel");
      end
      if ((CH_W < 1) || ((2 ** CH_W - 1) * 100 + 33 >= 2 ** RES_W)) begin : g_bad_res
         $error("RES_W too narrow for stub results");
      end
   endgenerate

   logic [PH_W-1:0]  phase;
   logic             start_req;
   logic             launch;
   logic             conv_done;
   logic [RES_W-1:0] conv_res;

   adc_seq_phase #(.DIV(DIV)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (phase)
   );

   adc_seq_trig #(
      .TRG_W   (TRG_W),
      .EXT_BIT (EXT_BIT),
      .TMR_BIT (TMR_BIT)
   ) u_trig (
      .trig_sel  (trig_sel),
      .sw_set    (sw_start_set),
      .ext_trig  (ext_trig),
      .tmr_req   (tmr_req),
      .start_req (start_req)
   );

   adc_seq_ctrl #(
      .CH_W    (CH_W),
      .RES_W   (RES_W),
      .DIV     (DIV),
      .PAD_CYC (PAD_CYC),
      .SPL_CYC (SPL_CYC),
      .GAP_CYC (GAP_CYC)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_req    (start_req),
      .abort        (sw_start_clr),
      .phase        (phase),
      .mode         (mode),
      .chan_sel     (chan_sel),
      .conv_done    (conv_done),
      .conv_res     (conv_res),
      .launch       (launch),
      .busy         (busy),
      .sh_active    (sh_active),
      .conv_active  (conv_active),
      .chan_idx     (chan_idx),
      .result_valid (result_valid),
      .result_data  (result_data),
      .result_chan  (result_chan),
      .eoc          (eoc)
   );

   adc_conv_stub #(
      .CH_W     (CH_W),
      .RES_W    (RES_W),
      .CONV_CYC (CONV_CYC)
   ) u_stub (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .flush  (sw_start_clr),
      .chan   (chan_idx),
      .done   (conv_done),
      .result (conv_res)
   );
endmodule

// File: rtl/adc_start_seq_chk.sv
module adc_start_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic sw_start_set,
   input logic sw_start_clr,
   input logic busy,
   input logic sh_active,
   input logic conv_active,
   input logic result_valid,
   input logic eoc
);
   // R2: a software start on an idle block raises busy
   a_r2_sw_start: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_start_set && !busy && !sw_start_clr) |=> busy);

   // R4: sampling only inside a busy sequence
   a_r4_sh_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      sh_active |-> busy);

   // R4: sampling and conversion never overlap
   a_r4_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sh_active, conv_active}));

   // R4: sampling ends straight into a conversion unless aborted
   a_r4_sample_to_conv: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sh_active) && !$past(sw_start_clr)) |-> conv_active);

   // R5: a finished conversion presents a result
   a_r5_result_after_conv: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(conv_active) && !$past(sw_start_clr)) |-> result_valid);

   // R8: end flag only together with a result
   a_r8_eoc_with_result: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |-> result_valid);

   // R9: results that do not end a pass keep the block busy
   a_r9_mid_result_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && !eoc) |-> busy);

   // R11: a clear stops everything in the next cycle
   a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
      sw_start_clr |=> (!busy && !result_valid && !eoc));
endmodule

bind adc_start_seq adc_start_seq_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sw_start_set (sw_start_set),
   .sw_start_clr (sw_start_clr),
   .busy         (busy),
   .sh_active    (sh_active),
   .conv_active  (conv_active),
   .result_valid (result_valid),
   .eoc          (eoc)
);

// File: tb/adc_start_seq_bench.sv
`timescale 1ns/1ps
module adc_start_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_start_set = 1'b0;
   logic       sw_start_clr = 1'b0;
   logic [3:0] trig_sel = 4'b0011;
   logic       ext_trig = 1'b0;
   logic       tmr_req = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [2:0] chan_sel = 3'd0;
   logic       busy, sh_active, conv_active, result_valid, eoc;
   logic [2:0] chan_idx, result_chan;
   logic [9:0] result_data;

   int n_run  = 0;
   int n_fail = 0;
   int ec     = 0;
   int wd     = 0;

   always #10 clk = ~clk;

   adc_start_seq u_adc_start_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .sw_start_set (sw_start_set),
      .sw_start_clr (sw_start_clr),
      .trig_sel     (trig_sel),
      .ext_trig     (ext_trig),
      .tmr_req      (tmr_req),
      .mode         (mode),
      .chan_sel     (chan_sel),
      .busy         (busy),
      .sh_active    (sh_active),
      .conv_active  (conv_active),
      .chan_idx     (chan_idx),
      .result_valid (result_valid),
      .result_data  (result_data),
      .result_chan  (result_chan),
      .eoc          (eoc)
   );

   always @(posedge clk) begin
      if (!rst_n) ec <= 0;
      else        ec <= ec + 1;
   end

   always @(posedge clk) begin
      wd <= wd + 1;
      if (wd > 150000) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // watch idle outputs for a while
   task automatic quiet(input int cycles, input string req);
      int bad = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (busy || result_valid || eoc || sh_active || conv_active) bad++;
      end
      check(bad == 0, req, bad, 0);
   endtask

   // src: 0 software, 1 external pin, 2 timer
   task automatic run_case(input int src, input logic [1:0] md, input logic [2:0] ch,
                           input bit disturb);
      bit single = (md == 2'b00) || (md == 2'b11);
      bit scan   = (md == 2'b10);
      int nch    = single ? 1 : int'(ch) + 1;
      int want   = scan ? 2 * nch : nch;
      int ph, td, base, k, sh_n, cv_n, guard, expch, expt;
      bit first_sh = 1'b1;
      mode     = md;
      chan_sel = ch;
      @(negedge clk);
      ph   = ec % 4;
      td   = (4 - ph) + 2;
      base = ec + 1;
      case (src)
         0: sw_start_set = 1'b1;
         1: ext_trig     = 1'b1;
         default: tmr_req = 1'b1;
      endcase
      @(negedge clk);
      sw_start_set = 1'b0;
      ext_trig     = 1'b0;
      tmr_req      = 1'b0;
      check(busy == 1'b1, "R2 start raises busy", busy, 1);
      k = 0; sh_n = 0; cv_n = 0; guard = 0;
      while (k < want && guard < 400) begin
         if (guard != 0) @(negedge clk);
         guard++;
         if (disturb && guard == 5) begin   // R10 stray requests and config edits
            sw_start_set = 1'b1; ext_trig = 1'b1; tmr_req = 1'b1;
            chan_sel = ~ch;
            mode = scan ? 2'b01 : 2'b10;
         end
         if (disturb && guard == 6) begin
            sw_start_set = 1'b0; ext_trig = 1'b0; tmr_req = 1'b0;
            chan_sel = ch;
            mode = md;
         end
         if (sh_active) begin
            sh_n++;
            if (first_sh) check(ec == base + td, "R3 start delay", ec - base, td);
            first_sh = 1'b0;
         end
         if (conv_active) cv_n++;
         if (result_valid) begin
            expt  = base + td + 18 + 12 * k;
            expch = single ? int'(ch) : (k % nch);
            check(ec == expt, (k == 0) ? "R5 first result time" : "R7 next result time",
                  ec - base, expt - base);
            check(int'(result_chan) == expch, "R6 channel order", result_chan, expch);
            check(int'(result_data) == expch * 100 + 33, "R5 result value",
                  result_data, expch * 100 + 33);
            check(eoc == ((k % nch) == nch - 1), scan ? "R9 pass end flag" : "R8 end flag",
                  eoc, ((k % nch) == nch - 1));
            if (!scan && k == nch - 1) check(busy == 1'b0, "R8 busy clears", busy, 0);
            else                       check(busy == 1'b1, "R9 busy held", busy, 1);
            k++;
         end
      end
      check(k == want, "R6 result count", k, want);
      check(sh_n == 8, "R4 sampling length", sh_n, 8);
      check(cv_n == 10 * want, "R5 conversion length", cv_n, 10 * want);
      if (scan) begin
         sw_start_clr = 1'b1;
         @(negedge clk);
         sw_start_clr = 1'b0;
         check(busy == 1'b0, "R11 clear stops scan", busy, 0);
         quiet(30, "R11 no output after clear");
      end else begin
         quiet(20, "R8 idle after sequence");
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(busy == 0 && eoc == 0 && result_valid == 0 && sh_active == 0 && conv_active == 0,
            "R1 reset state", {busy, eoc, result_valid, sh_active, conv_active}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 0 && eoc == 0 && result_valid == 0,
            "R1 after reset", {busy, eoc, result_valid}, 0);

      // R2 reserved enable bits only: hardware pulses ignored
      trig_sel = 4'b1100;
      @(negedge clk);
      ext_trig = 1'b1; tmr_req = 1'b1;
      @(negedge clk);
      ext_trig = 1'b0; tmr_req = 1'b0;
      quiet(10, "R2 disabled sources ignored");
      trig_sel = 4'b0011;

      // R3 every source at every divider phase
      for (int src = 0; src < 3; src++) begin
         for (int pad = 0; pad < 4; pad++) begin
            repeat (pad) @(negedge clk);
            run_case(src, 2'b00, 3'(src * 2 + pad), 1'b0);
         end
      end

      run_case(0, 2'b01, 3'd3, 1'b0);   // R6 multi group of four
      run_case(1, 2'b01, 3'd0, 1'b0);   // R6 multi with one channel
      run_case(2, 2'b11, 3'd5, 1'b0);   // R6 code 11 behaves as single
      run_case(0, 2'b10, 3'd2, 1'b1);   // R9 scan, R10 disturbance
      run_case(1, 2'b01, 3'd7, 1'b1);   // R7 full group, R10 disturbance

      // R11 abort in the middle of a multi sequence
      mode = 2'b01; chan_sel = 3'd3;
      @(negedge clk);
      sw_start_set = 1'b1;
      @(negedge clk);
      sw_start_set = 1'b0;
      repeat (25) @(negedge clk);
      check(busy == 1'b1, "R11 busy before clear", busy, 1);
      sw_start_clr = 1'b1;
      @(negedge clk);
      sw_start_clr = 1'b0;
      check(busy == 1'b0, "R11 clear mid sequence", busy, 0);
      quiet(40, "R11 no result after abort");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule